// File: doc/BRIEF.md
# Sync-Bit Rate Clock Measurement

This block measures a local clock by counting how many sync bits one of several line decoders reports during a fixed window. The window is timed by a slow reference: a one-cycle strobe that marks each period of a 32 kHz clock. The window lasts 2^9 such periods by default. Since the sync-bit rate of the incoming stream is known, the count tells software how far the local clock has drifted.

A measurement starts when software writes a decoder select code. While the measurement runs, the result register reads zero, so software polls until the value is non-zero. When the window closes, the register takes the count and holds it until the next write. The all-ones select code is a disable request. It never starts a window, and it cancels any window that is running.

Top module: `syncbit_clkmeas`

## Requirements
- R1: After reset, `meas_result` is 0 and no measurement is running.
- R2: A `cfg_wr` pulse with `cfg_sel` not equal to 2'b11 starts a measurement of decoder `cfg_sel`. From the next cycle until the window closes, `meas_result` reads 0.
- R3: The window closes on the 2^WIN_LOG2-th `ref_tick` cycle after the start write. In the following cycle `meas_result` equals the number of cycles in which the selected decoder's strobe was high. Counting starts with the cycle after the write and ends with the closing tick cycle, inclusive.
- R4: Only strobes from the selected decoder are counted. Strobe bit i of `sync_evt` belongs to decoder i.
- R5: A `cfg_wr` pulse with `cfg_sel` = 2'b11 starts nothing. It cancels any running measurement and sets `meas_result` to 0 in the next cycle.
- R6: A start write during a running measurement discards the partial count and the elapsed ticks. It then restarts the full window with the newly selected decoder.
- R7: The count saturates at the all-ones value of CNT_W bits and never wraps.
- R8: Once a measurement completes, `meas_result` holds its value regardless of `ref_tick` and `sync_evt` activity until the next `cfg_wr`.
- R9: Ticks and strobes in the cycle of a `cfg_wr` are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle write strobe for the select field |
| cfg_sel | input | 2 | Decoder select; 2'b11 requests disable |
| sync_evt | input | NUM_DEC | One-cycle sync-bit strobes, one per decoder |
| ref_tick | input | 1 | One-cycle strobe per 32 kHz reference period |
| meas_result | output | CNT_W | Measured count; 0 while busy |

## Verification
The bench builds the block with WIN_LOG2 = 3, so a window lasts eight reference ticks, and with CNT_W = 6, so the count saturates at 63. The short window lets a single run reach many closings. This covers restarts part-way through a window, aborts, ticks that land in the write cycle, and a strobe in the closing tick cycle. The narrow count makes saturation reachable within one window of dense strobes, which the default 16-bit width would not allow in a bounded run.

// File: rtl/clkmeas_pkg.sv
package clkmeas_pkg;
    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] SEL_OFF = 2'b11;

    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_RUN  = 1'b1
    } meas_state_e;
endpackage

// File: rtl/clkmeas_window.sv
module clkmeas_window #(
    parameter int WIN_LOG2 = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic last
);
    typedef struct packed {
        logic [WIN_LOG2-1:0] ticks;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (clear) begin
            win_d.ticks = '0;
        end else if (run && tick) begin
            win_d.ticks = win_q.ticks + 1'b1;
        end
    end

    assign last = run && tick && (win_q.ticks == {WIN_LOG2{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end
endmodule

// File: rtl/clkmeas_evcount.sv
module clkmeas_evcount #(
    parameter int NUM_DEC = 3,
    parameter int CNT_W   = 16,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               run,
    input  logic [NUM_DEC-1:0] evt,
    input  logic [SEL_W-1:0]   sel,
    output logic               hit,
    output logic [CNT_W-1:0]   count,
    output logic [CNT_W-1:0]   count_next
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [NUM_DEC-1:0] match;

    for (genvar g = 0; g < NUM_DEC; g++) begin : g_match
        assign match[g] = evt[g] && (sel == SEL_W'(g));
    end

    assign hit = run && (|match);

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d.cnt = '0;
        end else if (hit && (cnt_q.cnt != CNT_MAX)) begin
            cnt_d.cnt = cnt_q.cnt + 1'b1;
        end
    end

    assign count      = cnt_q.cnt;
    assign count_next = cnt_d.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/syncbit_clkmeas.sv
module syncbit_clkmeas
    import clkmeas_pkg::*;
#(
    parameter int NUM_DEC  = 3,
    parameter int WIN_LOG2 = 9,
    parameter int CNT_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_sel,
    input  logic [NUM_DEC-1:0] sync_evt,
    input  logic               ref_tick,
    output logic [CNT_W-1:0]   meas_result
);
    typedef struct packed {
        meas_state_e      st;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] res;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic             req_start;
    logic             req_stop;
    logic             meas_run;
    logic             win_last;
    logic             ev_hit;
    logic [CNT_W-1:0] ev_count;
    logic [CNT_W-1:0] ev_count_next;

    assign req_start = cfg_wr && (cfg_sel != SEL_OFF);
    assign req_stop  = cfg_wr && (cfg_sel == SEL_OFF);
    assign meas_run  = (ctl_q.st == MS_RUN) && !cfg_wr;

    clkmeas_window #(
        .WIN_LOG2 (WIN_LOG2)
    ) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cfg_wr),
        .run   (meas_run),
        .tick  (ref_tick),
        .last  (win_last)
    );

    clkmeas_evcount #(
        .NUM_DEC (NUM_DEC),
        .CNT_W   (CNT_W),
        .SEL_W   (SEL_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cfg_wr),
        .run        (meas_run),
        .evt        (sync_evt),
        .sel        (ctl_q.sel),
        .hit        (ev_hit),
        .count      (ev_count),
        .count_next (ev_count_next)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (req_start) begin
            ctl_d.st  = MS_RUN;
            ctl_d.sel = cfg_sel;
            ctl_d.res = '0;
        end else if (req_stop) begin
            ctl_d.st  = MS_IDLE;
            ctl_d.res = '0;
        end else if (win_last) begin
            ctl_d.st  = MS_IDLE;
            ctl_d.res = ev_count_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: MS_IDLE, sel: '0, res: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign meas_result = ctl_q.res;
endmodule

// File: rtl/syncbit_clkmeas_chk.sv
module syncbit_clkmeas_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [1:0]       cfg_sel,
    input logic             busy,
    input logic             ev_hit,
    input logic [CNT_W-1:0] ev_count,
    input logic [CNT_W-1:0] meas_result
);
    assert_busy_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (meas_result == '0));

    assert_start_goes_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel != 2'b11) |=> (busy && meas_result == '0));

    assert_disable_idles_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == 2'b11) |=> (!busy && meas_result == '0));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && ev_hit && ev_count == {CNT_W{1'b1}}) |=> (ev_count == {CNT_W{1'b1}}));

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_wr) |=> $stable(meas_result));

    assert_write_cycle_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (ev_count == '0));
endmodule

bind syncbit_clkmeas syncbit_clkmeas_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_sel     (cfg_sel),
    .busy        (ctl_q.st == clkmeas_pkg::MS_RUN),
    .ev_hit      (ev_hit),
    .ev_count    (ev_count),
    .meas_result (meas_result)
);

// File: tb/syncbit_clkmeas_tb.sv
module syncbit_clkmeas_tb;
    localparam int NUM_DEC  = 3;
    localparam int WIN_LOG2 = 3;
    localparam int CNT_W    = 6;
    localparam int WIN      = 1 << WIN_LOG2;
    localparam int CMAX     = (1 << CNT_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_wr = 1'b0;
    logic [1:0]         cfg_sel = 2'b00;
    logic [NUM_DEC-1:0] sync_evt = '0;
    logic               ref_tick = 1'b0;
    logic [CNT_W-1:0]   meas_result;

    int n_checks = 0;
    int n_errors = 0;

    // bench-side expectation state
    bit m_busy = 0;
    int m_sel  = 0;
    int m_cnt  = 0;
    int m_tk   = 0;
    int m_res  = 0;

    always #2 clk = ~clk;

    syncbit_clkmeas #(
        .NUM_DEC  (NUM_DEC),
        .WIN_LOG2 (WIN_LOG2),
        .CNT_W    (CNT_W)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_sel     (cfg_sel),
        .sync_evt    (sync_evt),
        .ref_tick    (ref_tick),
        .meas_result (meas_result)
    );

    task automatic check(input string req, input int exp);
        n_checks++;
        if (int'(meas_result) != exp) begin
            n_errors++;
            $display("FAIL %s: meas_result=%0d expected=%0d", req, meas_result, exp);
        end
    endtask

    // one cycle: drive at negedge, return at next negedge with outputs settled
    task automatic cyc(input bit wr, input int sel, input logic [NUM_DEC-1:0] ev, input bit tk);
        cfg_wr   = wr;
        cfg_sel  = 2'(sel);
        sync_evt = ev;
        ref_tick = tk;
        @(negedge clk);
        if (wr) begin
            if (sel != 3) begin
                m_busy = 1; m_sel = sel; m_cnt = 0; m_tk = 0; m_res = 0;
            end else begin
                m_busy = 0; m_res = 0;
            end
        end else if (m_busy) begin
            if (ev[m_sel] && m_cnt < CMAX) m_cnt++;
            if (tk) begin
                m_tk++;
                if (m_tk == WIN) begin
                    m_res = m_cnt; m_busy = 0;
                end
            end
        end
        cfg_wr = 0; sync_evt = '0; ref_tick = 0;
    endtask

    // run a window: tick every tper cycles, strobe pattern from ev_every
    task automatic run_window(input int tper, input int ev_every, input logic [NUM_DEC-1:0] evmask,
                              input string req);
        int guard = 0;
        while (m_busy && guard < 2000) begin
            cyc(0, 0, ((guard % ev_every) == 0) ? evmask : '0, (guard % tper) == tper - 1);
            if (m_busy && meas_result != '0) begin
                n_checks++; n_errors++;
                $display("FAIL %s: busy read %0d expected 0", req, meas_result);
            end
            guard++;
        end
    endtask

    task automatic t_reset;
        check("R1 reset value", 0);
        cyc(0, 0, 3'b111, 1);
        check("R1 idle after reset ignores activity", 0);
    endtask

    task automatic t_basic;
        cyc(1, 0, '0, 0);
        check("R2 busy reads zero", 0);
        run_window(3, 2, 3'b001, "R2");
        check("R3 decoder 0 count", m_res);
        n_checks++;
        if (m_res != 12) begin
            n_errors++;
            $display("FAIL R3: expectation %0d expected 12", m_res);
        end
    endtask

    task automatic t_select;
        cyc(1, 1, '0, 0);
        run_window(2, 1, 3'b010, "R4");
        check("R4 decoder 1 alone", m_res);
        cyc(1, 1, '0, 0);
        run_window(4, 1, 3'b101, "R4");
        check("R4 other decoders ignored", 0);
        cyc(1, 2, '0, 0);
        run_window(2, 3, 3'b111, "R4");
        check("R4 decoder 2 with all busy", m_res);
    endtask

    task automatic t_edges;
        cyc(1, 2, 3'b100, 1);           // strobe and tick in write cycle
        for (int i = 0; i < WIN - 1; i++) cyc(0, 0, '0, 1);
        cyc(0, 0, 3'b100, 1);           // strobe on closing tick
        check("R9 write-cycle tick and strobe ignored, closing strobe counted", 1);
    endtask

    task automatic t_restart;
        cyc(1, 0, '0, 0);
        for (int i = 0; i < 5; i++) cyc(0, 0, 3'b001, 1);
        cyc(1, 1, 3'b011, 1);
        check("R6 restart reads zero", 0);
        for (int i = 0; i < WIN - 1; i++) cyc(0, 0, 3'b010, 1);
        check("R6 still busy after partial window", 0);
        cyc(0, 0, 3'b011, 1);
        check("R6 restarted window count", WIN);
    endtask

    task automatic t_abort;
        cyc(1, 0, '0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 3'b001, 1);
        cyc(1, 3, 3'b001, 1);
        check("R5 abort reads zero", 0);
        for (int i = 0; i < 2 * WIN; i++) cyc(0, 0, 3'b111, 1);
        check("R5 abort leaves idle", 0);
        cyc(1, 1, '0, 0);
        run_window(1, 1, 3'b010, "R5");
        check("R5 setup result", WIN);
        cyc(1, 3, '0, 0);
        check("R5 disable while idle clears", 0);
    endtask

    task automatic t_saturate;
        cyc(1, 0, '0, 0);
        run_window(10, 1, 3'b001, "R7");
        check("R7 saturated count", CMAX);
    endtask

    task automatic t_hold;
        cyc(1, 2, '0, 0);
        run_window(2, 2, 3'b100, "R8");
        check("R8 result loaded", m_res);
        for (int i = 0; i < 3 * WIN; i++) cyc(0, 0, 3'b111, 1);
        check("R8 result held after activity", 8);
    endtask

    initial begin
        #(4 * 100000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_select();
        t_edges();
        t_restart();
        t_abort();
        t_saturate();
        t_hold();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule